// File: doc/BRIEF.md
# Snooping MESI Line-State Controller

This block tracks coherence for one private, direct-mapped cache that sits on a shared broadcast bus alongside a parameterised number of peer caches. For every line it holds a tag and one of four MESI states. Local core reads and writes either complete at once on a hit or become bus work: a read fetch, a fetch-for-ownership, an invalidate, or a write-back of a dirty victim. Every command that a peer places on the bus is snooped in the same cycle. The block answers with a data-supply indication, the shared wire or an invalidate acknowledgement, and it moves its own copy of the line to Shared or Invalid.

The core raises a request and holds the request, the write flag and the address until the block returns a one-cycle ready. The data array, bus arbitration and memory are outside the block. The block only states when its copy must be driven to the bus or written back to memory.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. A snooped read of any address returns supply low and shared low, and the first local read issues a bus read.
- R2: A read miss whose fill completes with bus_shared low installs the line as Exclusive. A later local write to that line completes with no bus command.
- R3: A read miss whose fill completes with bus_shared high installs the line as Shared. A later local write to that line issues an invalidate.
- R4: A write to a Shared line drives command 11 and keeps core_ready low until the number of set bits seen on inv_ack since the invalidate began reaches NUM_PEERS. The line is then Modified.
- R5: A write miss issues command 10 (read-exclusive) and installs the line as Modified. A following snooped read of it asserts snp_flush.
- R6: A snooped read (command 01) that hits a valid line asserts snp_supply and snp_shared in that cycle and leaves the line Shared. snp_flush is also high when the line was Modified.
- R7: A snooped read-exclusive or invalidate that hits a valid line makes it Invalid, so the next local read misses. A snooped invalidate always asserts snp_ack in the same cycle, hit or miss.
- R8: A miss whose victim line is Modified first raises wb_req with the victim's line-aligned address and waits for wb_done, and only then starts the fill.
- R9: A miss whose victim line is Exclusive or Shared starts the fill directly, with no write-back.
- R10: Bus commands are 2 bits: 00 idle, 01 read, 10 read-exclusive, 11 invalidate. bus_cmd and bus_addr stay stable until the transaction ends, and bus_addr has its offset bits zero.
- R11: A read hit, a write hit on a Modified line and a write hit on an Exclusive line raise core_ready in the cycle of the request, unless a snoop changing the same set arrives in that cycle. core_ready is never high while a bus command or a write-back is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | Core request, held until core_ready |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | ADDR_W | Byte address of the access |
| core_ready | output | 1 | Access complete (one cycle) |
| bus_cmd | output | 2 | Outgoing bus command |
| bus_addr | output | ADDR_W | Line-aligned address of bus_cmd |
| bus_done | input | 1 | Read or read-exclusive fill complete |
| bus_shared | input | 1 | A peer holds the line (sampled with bus_done) |
| inv_ack | input | NUM_PEERS | One bit per peer acknowledging an invalidate |
| wb_req | output | 1 | Write-back of a dirty victim requested |
| wb_addr | output | ADDR_W | Line-aligned victim address |
| wb_done | input | 1 | Write-back accepted by memory |
| snp_cmd | input | 2 | Peer command seen on the bus |
| snp_addr | input | ADDR_W | Address of the snooped command |
| snp_supply | output | 1 | This cache drives its copy of the line |
| snp_shared | output | 1 | Shared wire: this cache holds the line |
| snp_flush | output | 1 | Supplied copy is dirty; memory must take it |
| snp_ack | output | 1 | Acknowledge of a snooped invalidate |

## Verification
A wrong line state is hidden until the line is touched again, so each check pairs an action with the access or snoop that exposes it. Exclusive and Shared differ only in whether the next local write is silent or drives 11. Modified is visible only through snp_flush on a snooped read or through wb_req on eviction. A stale Invalid shows as a fresh bus read one cycle after the request. A wrong acknowledgement count shows as core_ready rising either earlier or later than the cycle in which the last peer acknowledges.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    MESI_I = 2'b00,
    MESI_S = 2'b01,
    MESI_E = 2'b10,
    MESI_M = 2'b11
  } mesi_e;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'b00,
    CMD_RD   = 2'b01,
    CMD_RDX  = 2'b10,
    CMD_INV  = 2'b11
  } bus_cmd_e;

  typedef enum logic [1:0] {
    F_IDLE,
    F_WB,
    F_FILL,
    F_INV
  } ctrl_fsm_e;

  function automatic mesi_e fill_state(input logic for_write, input logic peer_has);
    if (for_write) return MESI_M;
    return peer_has ? MESI_S : MESI_E;
  endfunction

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int TAG_W    = 22,
  localparam int IDX_W   = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ra_idx,
  output mesi_e            ra_state,
  output logic [TAG_W-1:0] ra_tag,
  input  logic [IDX_W-1:0] rb_idx,
  output mesi_e            rb_state,
  output logic [TAG_W-1:0] rb_tag,
  input  logic             wa_en,
  input  logic [IDX_W-1:0] wa_idx,
  input  mesi_e            wa_state,
  input  logic [TAG_W-1:0] wa_tag,
  input  logic             sw_en,
  input  logic [IDX_W-1:0] sw_idx,
  input  mesi_e            sw_state
);
  mesi_e            st_q  [NUM_SETS];
  logic [TAG_W-1:0] tag_q [NUM_SETS];

  assign ra_state = st_q[ra_idx];
  assign ra_tag   = tag_q[ra_idx];
  assign rb_state = st_q[rb_idx];
  assign rb_tag   = tag_q[rb_idx];

  // Snoop write follows the local write so a peer's action wins on a shared set.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SETS; i++) st_q[i] <= MESI_I;
    end else begin
      if (wa_en) st_q[wa_idx] <= wa_state;
      if (sw_en) st_q[sw_idx] <= sw_state;
    end
  end

  always_ff @(posedge clk) begin
    if (wa_en) tag_q[wa_idx] <= wa_tag;
  end
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
#(
  parameter int TAG_W = 22
) (
  input  logic [1:0]       cmd,
  input  logic [TAG_W-1:0] req_tag,
  input  mesi_e            line_state,
  input  logic [TAG_W-1:0] line_tag,
  output logic             hit,
  output logic             supply,
  output logic             shared_o,
  output logic             flush,
  output logic             ack,
  output logic             upd_en,
  output mesi_e            upd_state
);
  bus_cmd_e c;
  assign c   = bus_cmd_e'(cmd);
  assign hit = (c != CMD_IDLE) && (line_state != MESI_I) && (line_tag == req_tag);

  always_comb begin
    supply    = 1'b0;
    shared_o  = 1'b0;
    flush     = 1'b0;
    ack       = (c == CMD_INV);
    upd_en    = 1'b0;
    upd_state = line_state;
    if (hit) begin
      unique case (c)
        CMD_RD: begin
          supply    = 1'b1;
          shared_o  = 1'b1;
          flush     = (line_state == MESI_M);
          upd_en    = (line_state != MESI_S);
          upd_state = MESI_S;
        end
        CMD_RDX: begin
          supply    = 1'b1;
          flush     = (line_state == MESI_M);
          upd_en    = 1'b1;
          upd_state = MESI_I;
        end
        CMD_INV: begin
          upd_en    = 1'b1;
          upd_state = MESI_I;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mesi_ack_counter.sv
module mesi_ack_counter #(
  parameter int NUM_PEERS = 3,
  localparam int CNT_W = $clog2(NUM_PEERS + 1) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 active,
  input  logic [NUM_PEERS-1:0] ack_vec,
  output logic                 reached
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] sum;

  assign sum     = cnt_q + CNT_W'($countones(ack_vec));
  assign reached = active && (int'(sum) >= NUM_PEERS);

  always_ff @(posedge clk) begin
    if (!rst_n || !active) cnt_q <= '0;
    else if (!reached)     cnt_q <= sum;
  end
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int NUM_SETS   = 16,
  parameter int NUM_PEERS  = 3,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int IDX_W = $clog2(NUM_SETS),
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 core_req,
  input  logic                 core_we,
  input  logic [ADDR_W-1:0]    core_addr,
  output logic                 core_ready,
  output logic [1:0]           bus_cmd,
  output logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_done,
  input  logic                 bus_shared,
  input  logic [NUM_PEERS-1:0] inv_ack,
  output logic                 wb_req,
  output logic [ADDR_W-1:0]    wb_addr,
  input  logic                 wb_done,
  input  logic [1:0]           snp_cmd,
  input  logic [ADDR_W-1:0]    snp_addr,
  output logic                 snp_supply,
  output logic                 snp_shared,
  output logic                 snp_flush,
  output logic                 snp_ack
);
  function automatic logic [ADDR_W-1:0] line_align(input logic [ADDR_W-1:0] a);
    return a & ~ADDR_W'(LINE_BYTES - 1);
  endfunction
  function automatic logic [IDX_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  ctrl_fsm_e fsm_q, fsm_d;
  bus_cmd_e  cmd;

  logic [ADDR_W-1:0] core_line, snp_line;
  logic [IDX_W-1:0]  idx_c, idx_s;
  logic [TAG_W-1:0]  tag_c, tag_s, tag_v, tag_sl;
  mesi_e             st_c, st_s;
  logic              hit_c;

  logic              la_en;
  mesi_e             la_state;
  logic [TAG_W-1:0]  la_tag;

  logic              snp_hit, snp_upd_en, snp_conflict, inv_reached;
  mesi_e             snp_upd_state;

  // Named internal events for the checker.
  logic ev_fill_done, ev_inv_done, ev_wb_done, ev_silent_upgrade;

  assign core_line = line_align(core_addr);
  assign snp_line  = line_align(snp_addr);
  assign idx_c     = set_of(core_line);
  assign tag_c     = tag_of(core_line);
  assign idx_s     = set_of(snp_line);
  assign tag_s     = tag_of(snp_line);
  assign hit_c     = (st_c != MESI_I) && (tag_v == tag_c);
  assign snp_conflict = snp_upd_en && (idx_s == idx_c);

  mesi_line_store #(.NUM_SETS(NUM_SETS), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(idx_c), .ra_state(st_c), .ra_tag(tag_v),
    .rb_idx(idx_s), .rb_state(st_s), .rb_tag(tag_sl),
    .wa_en(la_en), .wa_idx(idx_c), .wa_state(la_state), .wa_tag(la_tag),
    .sw_en(snp_upd_en), .sw_idx(idx_s), .sw_state(snp_upd_state)
  );

  mesi_snoop_resp #(.TAG_W(TAG_W)) u_snoop (
    .cmd(snp_cmd), .req_tag(tag_s), .line_state(st_s), .line_tag(tag_sl),
    .hit(snp_hit), .supply(snp_supply), .shared_o(snp_shared), .flush(snp_flush),
    .ack(snp_ack), .upd_en(snp_upd_en), .upd_state(snp_upd_state)
  );

  mesi_ack_counter #(.NUM_PEERS(NUM_PEERS)) u_acks (
    .clk(clk), .rst_n(rst_n), .active(fsm_q == F_INV),
    .ack_vec(inv_ack), .reached(inv_reached)
  );

  always_comb begin
    fsm_d             = fsm_q;
    core_ready        = 1'b0;
    cmd               = CMD_IDLE;
    wb_req            = 1'b0;
    la_en             = 1'b0;
    la_state          = MESI_I;
    la_tag            = tag_c;
    ev_fill_done      = 1'b0;
    ev_inv_done       = 1'b0;
    ev_wb_done        = 1'b0;
    ev_silent_upgrade = 1'b0;
    unique case (fsm_q)
      F_IDLE: if (core_req && !snp_conflict) begin
        if (hit_c) begin
          if (!core_we || st_c == MESI_M) begin
            core_ready = 1'b1;
          end else if (st_c == MESI_E) begin
            core_ready        = 1'b1;
            ev_silent_upgrade = 1'b1;
            la_en             = 1'b1;
            la_state          = MESI_M;
          end else begin
            fsm_d = F_INV;
          end
        end else begin
          fsm_d = (st_c == MESI_M) ? F_WB : F_FILL;
        end
      end
      F_WB: begin
        wb_req = 1'b1;
        if (wb_done) begin
          ev_wb_done = 1'b1;
          la_en      = 1'b1;
          la_state   = MESI_I;
          la_tag     = tag_v;
          fsm_d      = F_FILL;
        end
      end
      F_FILL: begin
        cmd = core_we ? CMD_RDX : CMD_RD;
        if (bus_done) begin
          ev_fill_done = 1'b1;
          la_en        = 1'b1;
          la_state     = fill_state(core_we, bus_shared);
          fsm_d        = F_IDLE;
        end
      end
      F_INV: begin
        cmd = CMD_INV;
        if (inv_reached) begin
          ev_inv_done = 1'b1;
          la_en       = 1'b1;
          la_state    = MESI_M;
          fsm_d       = F_IDLE;
        end
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fsm_q <= F_IDLE;
    else        fsm_q <= fsm_d;
  end

  assign bus_cmd  = cmd;
  assign bus_addr = core_line;
  assign wb_addr  = {tag_v, idx_c, {OFF_W{1'b0}}};
endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk #(
  parameter int ADDR_W    = 32,
  parameter int NUM_PEERS = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 core_ready,
  input logic [1:0]           bus_cmd,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [ADDR_W-1:0]    snp_addr,
  input logic [1:0]           snp_cmd,
  input logic [NUM_PEERS-1:0] inv_ack,
  input logic                 wb_req,
  input logic                 snp_supply,
  input logic                 snp_flush,
  input logic                 ev_fill_done,
  input logic                 ev_inv_done
);
  int acks_seen;

  always_ff @(posedge clk) begin
    if (!rst_n)                acks_seen <= 0;
    else if (bus_cmd == 2'b11) acks_seen <= acks_seen + $countones(inv_ack);
    else                       acks_seen <= 0;
  end

  // R11: completion only with the bus and write-back path quiet
  assert_ready_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    core_ready |-> (bus_cmd == 2'b00 && !wb_req));

  // R10: an outstanding command holds command and address
  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != 2'b00 && !ev_fill_done && !ev_inv_done)
      |=> (bus_cmd == $past(bus_cmd) && bus_addr == $past(bus_addr)));

  // R4: an invalidate ends only after every peer acknowledged
  assert_ack_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_cmd) == 2'b11 && bus_cmd != 2'b11) |-> acks_seen >= NUM_PEERS);

  // R8: no fill is issued while a write-back is pending
  assert_no_fill_during_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> bus_cmd == 2'b00);

  // R6: a dirty flush always comes with data supply
  assert_flush_supply_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> snp_supply);

  // R6: after a supplied snoop read the line is no longer dirty
  assert_drop_shared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_cmd == 2'b01 && snp_supply)
      |=> !(snp_cmd != 2'b00 && snp_addr == $past(snp_addr) && snp_flush));
endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk #(.ADDR_W(ADDR_W), .NUM_PEERS(NUM_PEERS)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_ready(core_ready), .bus_cmd(bus_cmd),
  .bus_addr(bus_addr), .snp_addr(snp_addr), .snp_cmd(snp_cmd), .inv_ack(inv_ack),
  .wb_req(wb_req), .snp_supply(snp_supply), .snp_flush(snp_flush),
  .ev_fill_done(ev_fill_done), .ev_inv_done(ev_inv_done)
);

// File: tb/test_mesi_snoop_ctrl.sv
module test_mesi_snoop_ctrl;
  localparam int AW = 32;
  localparam int LB = 64;
  localparam int NS = 16;
  localparam int NP = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          core_req = 1'b0, core_we = 1'b0;
  logic [AW-1:0] core_addr = '0;
  logic          core_ready;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic          bus_done = 1'b0, bus_shared = 1'b0;
  logic [NP-1:0] inv_ack = '0;
  logic          wb_req;
  logic [AW-1:0] wb_addr;
  logic          wb_done = 1'b0;
  logic [1:0]    snp_cmd = 2'b00;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_supply, snp_shared, snp_flush, snp_ack;

  int  n_checks = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  mesi_snoop_ctrl #(.ADDR_W(AW), .LINE_BYTES(LB), .NUM_SETS(NS), .NUM_PEERS(NP)) i_mesi_snoop_ctrl (
    .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_we(core_we), .core_addr(core_addr),
    .core_ready(core_ready), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_done(bus_done),
    .bus_shared(bus_shared), .inv_ack(inv_ack), .wb_req(wb_req), .wb_addr(wb_addr),
    .wb_done(wb_done), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_supply(snp_supply),
    .snp_shared(snp_shared), .snp_flush(snp_flush), .snp_ack(snp_ack)
  );

  localparam logic [AW-1:0] A_LINE = 32'h0000_1000;  // set 0
  localparam logic [AW-1:0] B_LINE = 32'h0000_2000;  // set 0, other tag
  localparam logic [AW-1:0] C_LINE = 32'h0000_1040;  // set 1

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Core access with a bus/memory responder; one peer acknowledges per cycle.
  task automatic access(input logic we, input logic [AW-1:0] addr, input logic peer_has,
                        output logic [1:0] first_cmd, output bit saw_wb,
                        output logic [AW-1:0] wb_a, output int inv_cycles,
                        output int wait_cycles, output bit addr_ok);
    int acks = 0;
    first_cmd = 2'b00; saw_wb = 1'b0; wb_a = '0; inv_cycles = 0; wait_cycles = 0;
    addr_ok = 1'b1;
    @(negedge clk);
    core_req = 1'b1; core_we = we; core_addr = addr;
    for (int k = 0; k < 60; k++) begin
      #1;
      if (core_ready) break;
      if (wb_req) begin
        saw_wb = 1'b1; wb_a = wb_addr; wb_done = 1'b1;
      end else if (bus_cmd != 2'b00) begin
        if (first_cmd == 2'b00) first_cmd = bus_cmd;
        if (bus_addr != (addr & ~AW'(LB - 1))) addr_ok = 1'b0;
        if (bus_cmd == 2'b11) begin
          inv_cycles++;
          if (acks < NP) inv_ack = NP'(1) << acks;
          acks++;
        end else begin
          bus_done = 1'b1; bus_shared = peer_has;
        end
      end
      wait_cycles++;
      @(posedge clk);
      @(negedge clk);
      bus_done = 1'b0; bus_shared = 1'b0; wb_done = 1'b0; inv_ack = '0;
    end
    @(posedge clk);
    @(negedge clk);
    core_req = 1'b0; core_we = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] addr,
                       output bit sup, output bit shr, output bit fl, output bit ak);
    @(negedge clk);
    snp_cmd = cmd; snp_addr = addr;
    #1;
    sup = snp_supply; shr = snp_shared; fl = snp_flush; ak = snp_ack;
    @(posedge clk);
    @(negedge clk);
    snp_cmd = 2'b00;
  endtask

  logic [1:0]    fc;
  bit            wbs, aok, sup, shr, fl, ak;
  logic [AW-1:0] wba;
  int            invc, waitc;

  task automatic t_reset();
    snoop(2'b01, A_LINE + 32'h8, sup, shr, fl, ak);
    check(!sup && !shr, "R1", "snoop after reset supply/shared", {sup, shr}, 0);
    access(1'b0, A_LINE + 32'h4, 1'b0, fc, wbs, wba, invc, waitc, aok);
    check(fc == 2'b01, "R1", "first read issues bus read", fc, 1);
    check(aok, "R10", "bus_addr line aligned", aok, 1);
  endtask

  task automatic t_exclusive_and_upgrade();
    access(1'b1, A_LINE, 1'b0, fc, wbs, wba, invc, waitc, aok);
    check(fc == 2'b00 && waitc == 0, "R2", "write to Exclusive is silent", {fc, 8'(waitc)}, 0);
    snoop(2'b01, A_LINE, sup, shr, fl, ak);
    check(sup && shr && fl, "R6", "snoop read of Modified supply/shared/flush", {sup, shr, fl}, 7);
    access(1'b1, A_LINE, 1'b0, fc, wbs, wba, invc, waitc, aok);
    check(fc == 2'b11, "R6", "line Shared after snoop: write invalidates", fc, 3);
    check(invc == NP, "R4", "invalidate held until all acks", invc, NP);
    snoop(2'b01, A_LINE, sup, shr, fl, ak);
    check(fl, "R4", "line Modified after invalidate", fl, 1);
    access(1'b1, A_LINE, 1'b0, fc, wbs, wba, invc, waitc, aok);
    check(fc == 2'b11 && invc == NP, "R4", "second upgrade acks", invc, NP);
  endtask

  task automatic t_evict_dirty();
    access(1'b0, B_LINE + 32'h10, 1'b1, fc, wbs, wba, invc, waitc, aok);
    check(wbs && wba == A_LINE, "R8", "dirty victim written back", wba, A_LINE);
    check(fc == 2'b01, "R8", "fill follows write-back", fc, 1);
    access(1'b1, B_LINE, 1'b0, fc, wbs, wba, invc, waitc, aok);
    check(fc == 2'b11, "R3", "shared fill needs invalidate on write", fc, 3);
  endtask

  task automatic t_snoop_invalidate();
    snoop(2'b11, B_LINE, sup, shr, fl, ak);
    check(ak && !sup, "R7", "invalidate hit acked, no supply", {ak, sup}, 2);
    access(1'b0, B_LINE, 1'b0, fc, wbs, wba, invc, waitc, aok);
    check(fc == 2'b01 && !wbs, "R7", "line Invalid after snooped invalidate", {fc, wbs}, 2);
    snoop(2'b11, C_LINE, sup, shr, fl, ak);
    check(ak, "R7", "invalidate miss still acked", ak, 1);
  endtask

  task automatic t_evict_clean();
    access(1'b0, A_LINE, 1'b0, fc, wbs, wba, invc, waitc, aok);
    check(!wbs && fc == 2'b01, "R9", "clean victim dropped silently", {wbs, fc}, 1);
    access(1'b0, A_LINE + 32'h3C, 1'b0, fc, wbs, wba, invc, waitc, aok);
    check(fc == 2'b00 && waitc == 0, "R11", "read hit ready in request cycle", waitc, 0);
  endtask

  task automatic t_write_miss();
    access(1'b1, C_LINE + 32'h20, 1'b0, fc, wbs, wba, invc, waitc, aok);
    check(fc == 2'b10, "R5", "write miss issues read-exclusive", fc, 2);
    check(aok, "R10", "read-exclusive address aligned", aok, 1);
    access(1'b1, C_LINE, 1'b0, fc, wbs, wba, invc, waitc, aok);
    check(fc == 2'b00 && waitc == 0, "R11", "write hit on Modified immediate", waitc, 0);
    snoop(2'b01, C_LINE, sup, shr, fl, ak);
    check(fl && sup, "R5", "installed Modified flushes on snoop", {fl, sup}, 3);
    snoop(2'b10, C_LINE, sup, shr, fl, ak);
    check(sup && !fl, "R7", "read-exclusive hit on Shared supplies clean", {sup, fl}, 2);
    access(1'b0, C_LINE, 1'b0, fc, wbs, wba, invc, waitc, aok);
    check(fc == 2'b01, "R7", "line Invalid after snooped read-exclusive", fc, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check(!core_ready && bus_cmd == 2'b00 && !wb_req, "R1", "outputs quiet in reset",
          {core_ready, bus_cmd, wb_req}, 0);
    rst_n = 1'b1;
    t_reset();
    t_exclusive_and_upgrade();
    t_evict_dirty();
    t_snoop_invalidate();
    t_evict_clean();
    t_write_miss();
    repeat (2) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end
endmodule